// File: doc/BRIEF.md
# Field-Masked Process Context Register

This block holds the context state of the running process as five independent fields: an 8-bit address-space identifier, a 4-bit asynchronous-trap enable set, a 4-bit asynchronous-trap request set, a one-bit performance-counting enable and a one-bit floating-point enable. Privileged code updates it through a move-to-register port that carries an 8-bit register index and a 64-bit data word.

The two top index bits pick this register. The five low index bits form a write mask with one bit per field, so a single write can update any subset of the fields and leave the rest alone. The read port always shows every field at its fixed position in one word. Fields are held in registers, so a write is seen on the read port one cycle later.

Top module: `ctx_reg_top`

## Requirements
- R1: A write is accepted only when `wr_en` is 1 and `wr_index[7:6]` equals 2'b01. Any other selector value leaves every field unchanged. `wr_index[5]` has no effect.
- R2: When a write is accepted, `wr_index[0]` enables the address-space field, `[1]` the trap-enable field, `[2]` the trap-request field, `[3]` the performance enable and `[4]` the floating-point enable.
- R3: A field whose mask bit is 0 keeps its value during an accepted write.
- R4: One accepted write with mask 5'b11111 updates all five fields together.
- R5: An accepted write with mask 5'b00000 changes nothing.
- R6: Writes and reads use the same bit positions: address space in data[46:39], trap enable in data[16:13], trap request in data[12:9], performance enable in data[1], floating-point enable in data[2].
- R7: All `rd_data` bits outside the R6 positions read as 0.
- R8: A write is visible on `rd_data` after the next rising clock edge. In the cycle of the write, `rd_data` still shows the old values.
- R9: A synchronous active-high `rst` clears every field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to-register write strobe |
| wr_index | input | 8 | Register index: [7:6] selector, [4:0] field mask |
| wr_data | input | 64 | Write data in the R6 layout |
| rd_data | output | 64 | All fields in the R6 layout |

## Verification
The assertions check four things on every clock edge: unselected and zero-mask writes leave `rd_data` stable, each field register holds when its enable is low, it loads its slice one edge after the enable, and reset clears the word. Only the bench scenarios can show that index bits map to the correct fields and data positions, that reserved bits read as zero under random data, and that reads in the write cycle return the old value.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int NUM_FIELDS = 5;

  // Field order follows the index-mask bit order.
  function automatic int fld_width(input int i);
    case (i)
      0: return 8;
      1: return 4;
      2: return 4;
      3: return 1;
      default: return 1;
    endcase
  endfunction

  function automatic int fld_lsb(input int i);
    case (i)
      0: return 39;
      1: return 13;
      2: return 9;
      3: return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/ctx_sel_decode.sv
module ctx_sel_decode #(
  parameter int IDX_W = 8,
  parameter int NF    = 5,
  parameter logic [1:0] SEL_CODE = 2'b01
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  output logic [NF-1:0]    fld_we
);
  logic hit;

  always_comb begin
    hit    = wr_en && (wr_index[IDX_W-1 -: 2] == SEL_CODE);
    fld_we = hit ? wr_index[NF-1:0] : '0;
  end
endmodule

// File: rtl/ctx_field_reg.sv
module ctx_field_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R3: a field whose enable is low holds its value
  a_r3_hold_unmasked: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

  // R8: an enabled field shows the written data one edge later
  a_r8_load_next: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(d)));
endmodule

// File: rtl/ctx_reg_top.sv
module ctx_reg_top #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  import ctx_pkg::*;
  localparam int NF = NUM_FIELDS;

  logic [NF-1:0]     fld_we;
  logic [DATA_W-1:0] part [NF];

  ctx_sel_decode #(.IDX_W(IDX_W), .NF(NF), .SEL_CODE(2'b01)) u_dec (
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .fld_we   (fld_we)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam int FW  = fld_width(g);
    localparam int FL  = fld_lsb(g);
    logic [FW-1:0] q;

    ctx_field_reg #(.W(FW)) u_reg (
      .clk (clk),
      .rst (rst),
      .we  (fld_we[g]),
      .d   (wr_data[FL +: FW]),
      .q   (q)
    );

    always_comb begin
      part[g]          = '0;
      part[g][FL +: FW] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NF; i++) rd_data = rd_data | part[i];
  end

  // R1: writes to another register leave the whole word stable
  a_r1_unselected_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_index[IDX_W-1 -: 2] != 2'b01) |=> $stable(rd_data));

  // R5: a write with an empty mask leaves the whole word stable
  a_r5_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_index[NF-1:0] == '0) |=> $stable(rd_data));

  // R9: reset clears every field
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/ctx_reg_top_tb.sv
module ctx_reg_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_index;
  logic [63:0] wr_data;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_sp;
  logic [3:0] m_te, m_tr;
  logic       m_pe, m_fe;

  always #2.5 clk = ~clk;

  ctx_reg_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [63:0] expect_word();
    logic [63:0] w = '0;
    w[46:39] = m_sp;
    w[16:13] = m_te;
    w[12:9]  = m_tr;
    w[1]     = m_pe;
    w[2]     = m_fe;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  // Drive one cycle at the negedge, check the old value (R8), update model at the edge.
  task automatic cycle(input logic en, input logic [7:0] idx, input logic [63:0] d,
                       input string req);
    @(negedge clk);
    wr_en = en; wr_index = idx; wr_data = d;
    #1 check("R8 same-cycle old value", expect_word());
    @(posedge clk);
    if (en && idx[7:6] == 2'b01) begin
      if (idx[0]) m_sp = d[46:39];
      if (idx[1]) m_te = d[16:13];
      if (idx[2]) m_tr = d[12:9];
      if (idx[3]) m_pe = d[1];
      if (idx[4]) m_fe = d[2];
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(req, expect_word());
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; wr_index = '0; wr_data = '0;
    m_sp = '0; m_te = '0; m_tr = '0; m_pe = 1'b0; m_fe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", 64'h0);
    rst = 1'b0;

    // R4 / R6 / R7: all fields in one write, all data bits set
    cycle(1'b1, 8'b01_0_11111, '1, "R4 R6 R7 full write");
    // R5: empty mask
    cycle(1'b1, 8'b01_0_00000, 64'h0, "R5 empty mask");
    // R2 / R3: each mask bit alone clears only its field
    for (int b = 0; b < 5; b++)
      cycle(1'b1, 8'b0100_0000 | (8'd1 << b), 64'h0, "R2 R3 single field");
    cycle(1'b1, 8'b01_0_11111, 64'h0000_5A00_0001_5E06, "R6 pattern");
    // R1: other selectors and no strobe
    cycle(1'b1, 8'b00_0_11111, '1, "R1 selector 00");
    cycle(1'b1, 8'b10_0_11111, '1, "R1 selector 10");
    cycle(1'b1, 8'b11_0_11111, '1, "R1 selector 11");
    cycle(1'b0, 8'b01_0_11111, '1, "R1 no strobe");
    cycle(1'b1, 8'b01_1_00101, '1, "R1 bit5 ignored");

    for (int n = 0; n < 400; n++) begin
      logic [7:0]  idx = $urandom();
      logic [63:0] d   = {$urandom(), $urandom()};
      if ($urandom_range(0, 1)) idx[7:6] = 2'b01;
      cycle($urandom_range(0, 3) != 0, idx, d, "R2 R3 R7 random");
    end

    // R9: reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_sp = '0; m_te = '0; m_tr = '0; m_pe = 1'b0; m_fe = 1'b0;
    check("R9 reset clears", 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule